// File: doc/BRIEF.md
# Nibble ALU with Chained Carry

This block is a four-bit arithmetic and logic unit for a small accumulator-style datapath. A left operand is picked from the program counter, the B register or the Y register. A right operand is picked from the C register, the bitwise complement of C, the constant one, or an immediate field. One operation code then selects one of three kinds of operation: binary addition with a fixed or chained carry, a one-place right rotation through the carry, or a bitwise function. The result, a zero indication and the carry the operation would produce all appear combinationally in the same cycle.

A single carry flip-flop holds the carry of the last operation that was committed. The surrounding datapath commits it with a write strobe. Subtraction has no separate subtractor. The caller selects the complemented C as the right operand, and the adder runs with a carry-in of one. The flag then records a borrow, which is the inverse of the adder's carry out. Add and subtract with carry, and the shift, read the stored flag. This lets multi-nibble arithmetic be chained across several instructions.

Top module: `nibalu`

## Requirements
- R1: A high `rst` at a rising clock edge clears `carry_q` to 0. Reset takes priority over `flag_we`.
- R2: `src_a_sel` picks the left operand: 0 selects `pc_in`, 1 selects `b_in`, and 2 or 3 select `y_in`.
- R3: `src_b_sel` picks the right operand: 0 selects `c_in`, 1 selects the bitwise complement of `c_in`, 2 selects the constant 1, and 3 selects `imm_in`.
- R4: With `op` = 0 (add), `result` is the low four bits of left + right, and `carry_next` is the adder's carry out.
- R5: With `op` = 1 (subtract), `result` is the low four bits of left + right + 1, and `carry_next` is the inverse of the adder's carry out. Selecting the complemented C therefore gives left − C, with `carry_next` = 1 on a borrow.
- R6: With `op` = 2 (add with carry), the adder carry-in is `carry_q` and the flag is taken as in R4. With `op` = 3 (subtract with carry), the carry-in is the inverse of `carry_q` and the flag is taken as in R5.
- R7: With `op` = 4 (shift right through carry), `result` is {`carry_q`, left[3:1]} and `carry_next` is left[0].
- R8: Codes 5, 6, 7 and 8 give left AND right, left OR right, left XOR right and NOT left. For these codes `carry_next` equals `carry_q`.
- R9: With `op` = 7 and `src_b_sel` = 1, `result` is the complement of `c_in` and does not depend on the left operand.
- R10: Codes 9 to 15 give `result` = 0, and `carry_next` equals `carry_q`.
- R11: `zero` is 1 exactly when all four bits of `result` are 0.
- R12: At a rising edge with `flag_we` high and `rst` low, `carry_q` takes `carry_next`. With `flag_we` low, `carry_q` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the carry flag |
| src_a_sel | input | 2 | Left operand select |
| src_b_sel | input | 2 | Right operand select |
| op | input | 4 | Operation code |
| flag_we | input | 1 | Commit `carry_next` into `carry_q` |
| pc_in | input | 4 | Program counter value |
| b_in | input | 4 | B register value |
| y_in | input | 4 | Y register value |
| c_in | input | 4 | C register value |
| imm_in | input | 4 | Immediate field |
| result | output | 4 | Operation result |
| zero | output | 1 | Result is all zeros |
| carry_next | output | 1 | Carry or borrow this operation produces |
| carry_q | output | 1 | Stored carry from the last committed operation |

## Verification
The assertions assume that `rst` is held for at least one edge before any operation is applied. They also assume that `op`, `flag_we` and the select inputs never carry unknown values at a sampling edge. The bench drives every input from time zero, with reset high. It changes inputs only between edges, so the flag properties always see a defined `carry_next` one cycle before the register they check. The operand data is also known at every edge, because every selectable source is driven whether or not it is used.

// File: rtl/nibalu_pkg.sv
package nibalu_pkg;

  localparam int OP_W  = 4;
  localparam int SEL_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADDC = 4'd2,
    OP_SUBC = 4'd3,
    OP_SHR  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_NOT  = 4'd8
  } alu_op_e;

  localparam logic [SEL_W-1:0] ASEL_PC  = 2'd0;
  localparam logic [SEL_W-1:0] ASEL_B   = 2'd1;

  localparam logic [SEL_W-1:0] BSEL_C    = 2'd0;
  localparam logic [SEL_W-1:0] BSEL_NC   = 2'd1;
  localparam logic [SEL_W-1:0] BSEL_ONE  = 2'd2;
  localparam logic [SEL_W-1:0] BSEL_IMM  = 2'd3;

endpackage

// File: rtl/nibalu_opsel.sv
module nibalu_opsel
  import nibalu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [SEL_W-1:0] a_sel,
  input  logic [SEL_W-1:0] b_sel,
  input  logic [W-1:0]     pc_val,
  input  logic [W-1:0]     b_val,
  input  logic [W-1:0]     y_val,
  input  logic [W-1:0]     c_val,
  input  logic [W-1:0]     imm_val,
  output logic [W-1:0]     left_op,
  output logic [W-1:0]     right_op,
  output logic             right_is_nc
);

  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    unique case (a_sel)
      ASEL_PC: left_op = pc_val;
      ASEL_B:  left_op = b_val;
      default: left_op = y_val;
    endcase
  end

  always_comb begin
    unique case (b_sel)
      BSEL_C:   right_op = c_val;
      BSEL_NC:  right_op = ~c_val;
      BSEL_ONE: right_op = ONE;
      default:  right_op = imm_val;
    endcase
  end

  assign right_is_nc = (b_sel == BSEL_NC);

endmodule

// File: rtl/nibalu_adder.sv
module nibalu_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  logic [W:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic half;
    assign half       = x[i] ^ y[i];
    assign sum[i]     = half ^ chain[i];
    assign chain[i+1] = (x[i] & y[i]) | (half & chain[i]);
  end

  assign cout = chain[W];

endmodule

// File: rtl/nibalu_logic.sv
module nibalu_logic
  import nibalu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    left_op,
  input  logic [W-1:0]    right_op,
  input  logic            right_is_nc,
  output logic [W-1:0]    bits_out
);

  always_comb begin
    unique case (op)
      OP_AND:  bits_out = left_op & right_op;
      OP_OR:   bits_out = left_op | right_op;
      OP_XOR:  bits_out = right_is_nc ? right_op : (left_op ^ right_op);
      OP_NOT:  bits_out = ~left_op;
      default: bits_out = '0;
    endcase
  end

endmodule

// File: rtl/nibalu.sv
module nibalu
  import nibalu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] src_a_sel,
  input  logic [SEL_W-1:0] src_b_sel,
  input  logic [OP_W-1:0]  op,
  input  logic             flag_we,
  input  logic [W-1:0]     pc_in,
  input  logic [W-1:0]     b_in,
  input  logic [W-1:0]     y_in,
  input  logic [W-1:0]     c_in,
  input  logic [W-1:0]     imm_in,
  output logic [W-1:0]     result,
  output logic             zero,
  output logic             carry_next,
  output logic             carry_q
);

  localparam int MSB = W - 1;

  logic [W-1:0] left_op;
  logic [W-1:0] right_op;
  logic         right_is_nc;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic         add_cin;
  logic [W-1:0] logic_bits;
  logic [W-1:0] shr_bits;

  nibalu_opsel #(.W(W)) u_opsel (
    .a_sel       (src_a_sel),
    .b_sel       (src_b_sel),
    .pc_val      (pc_in),
    .b_val       (b_in),
    .y_val       (y_in),
    .c_val       (c_in),
    .imm_val     (imm_in),
    .left_op     (left_op),
    .right_op    (right_op),
    .right_is_nc (right_is_nc)
  );

  always_comb begin
    unique case (op)
      OP_SUB:  add_cin = 1'b1;
      OP_ADDC: add_cin = carry_q;
      OP_SUBC: add_cin = ~carry_q;
      default: add_cin = 1'b0;
    endcase
  end

  nibalu_adder #(.W(W)) u_adder (
    .x    (left_op),
    .y    (right_op),
    .cin  (add_cin),
    .sum  (add_sum),
    .cout (add_cout)
  );

  nibalu_logic #(.W(W)) u_logic (
    .op          (op),
    .left_op     (left_op),
    .right_op    (right_op),
    .right_is_nc (right_is_nc),
    .bits_out    (logic_bits)
  );

  assign shr_bits = {carry_q, left_op[MSB:1]};

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDC: begin
        result     = add_sum;
        carry_next = add_cout;
      end
      OP_SUB, OP_SUBC: begin
        result     = add_sum;
        carry_next = ~add_cout;
      end
      OP_SHR: begin
        result     = shr_bits;
        carry_next = left_op[0];
      end
      default: begin
        result     = logic_bits;
        carry_next = carry_q;
      end
    endcase
  end

  assign zero = ~|result;

  always_ff @(posedge clk) begin
    if (rst)          carry_q <= 1'b0;
    else if (flag_we) carry_q <= carry_next;
  end

endmodule

// File: rtl/nibalu_chk.sv
module nibalu_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op,
  input logic         flag_we,
  input logic [W-1:0] result,
  input logic         zero,
  input logic         carry_next,
  input logic         carry_q
);

  AST_RST_CLEAR: assert property (@(posedge clk) rst |=> !carry_q); // R1
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> carry_q == $past(carry_next)); // R12
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(carry_q)); // R12
  AST_SHR_TOP: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd4) |-> result[W-1] == carry_q); // R7
  AST_LOGIC_KEEP: assert property (@(posedge clk) disable iff (rst)
    (op >= 4'd5) |-> carry_next == carry_q); // R8
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op > 4'd8) |-> zero); // R10
  AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (rst)
    zero |-> result == '0); // R11

endmodule

bind nibalu nibalu_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .op         (op),
  .flag_we    (flag_we),
  .result     (result),
  .zero       (zero),
  .carry_next (carry_next),
  .carry_q    (carry_q)
);

// File: tb/test_nibalu.sv
module test_nibalu;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] src_a_sel = 2'd1;
  logic [1:0] src_b_sel = 2'd0;
  logic [3:0] op = 4'd0;
  logic       flag_we = 1'b0;
  logic [3:0] pc_in = 4'h3;
  logic [3:0] b_in = 4'h0;
  logic [3:0] y_in = 4'h6;
  logic [3:0] c_in = 4'h0;
  logic [3:0] imm_in = 4'hE;
  logic [3:0] result;
  logic       zero;
  logic       carry_next;
  logic       carry_q;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nibalu i_nibalu (
    .clk(clk), .rst(rst), .src_a_sel(src_a_sel), .src_b_sel(src_b_sel),
    .op(op), .flag_we(flag_we), .pc_in(pc_in), .b_in(b_in), .y_in(y_in),
    .c_in(c_in), .imm_in(imm_in), .result(result), .zero(zero),
    .carry_next(carry_next), .carry_q(carry_q)
  );

  typedef struct packed {
    logic [3:0] tag;
    logic [1:0] asel;
    logic [1:0] bsel;
    logic [3:0] opc;
    logic [3:0] bv;
    logic [3:0] cv;
    logic       cf;
    logic [3:0] res;
    logic       cn;
  } vec_t;

  // pc=3, y=6, imm=E in every vector
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  2'd0, 2'd0, 4'd0, 4'h9, 4'h5, 1'b0, 4'h8, 1'b0},
    '{4'd3,  2'd2, 2'd2, 4'd0, 4'h9, 4'h5, 1'b0, 4'h7, 1'b0},
    '{4'd2,  2'd3, 2'd3, 4'd0, 4'h9, 4'h5, 1'b0, 4'h4, 1'b1},
    '{4'd5,  2'd1, 2'd1, 4'd1, 4'h9, 4'h5, 1'b0, 4'h4, 1'b0},
    '{4'd5,  2'd1, 2'd1, 4'd1, 4'h2, 4'h5, 1'b0, 4'hD, 1'b1},
    '{4'd6,  2'd1, 2'd0, 4'd2, 4'h9, 4'h5, 1'b1, 4'hF, 1'b0},
    '{4'd6,  2'd1, 2'd1, 4'd3, 4'h9, 4'h5, 1'b1, 4'h3, 1'b0},
    '{4'd7,  2'd1, 2'd0, 4'd4, 4'h9, 4'h5, 1'b1, 4'hC, 1'b1},
    '{4'd7,  2'd1, 2'd0, 4'd4, 4'h6, 4'h5, 1'b0, 4'h3, 1'b0},
    '{4'd8,  2'd2, 2'd1, 4'd6, 4'h9, 4'h5, 1'b1, 4'hE, 1'b1},
    '{4'd9,  2'd1, 2'd1, 4'd7, 4'h9, 4'h5, 1'b0, 4'hA, 1'b0},
    '{4'd8,  2'd1, 2'd0, 4'd7, 4'h9, 4'h5, 1'b1, 4'hC, 1'b1},
    '{4'd8,  2'd1, 2'd0, 4'd5, 4'h9, 4'h5, 1'b0, 4'h1, 1'b0},
    '{4'd8,  2'd1, 2'd0, 4'd8, 4'h9, 4'h5, 1'b0, 4'h6, 1'b0},
    '{4'd10, 2'd1, 2'd0, 4'd12, 4'h9, 4'h5, 1'b1, 4'h0, 1'b1},
    '{4'd11, 2'd1, 2'd1, 4'd1, 4'h5, 4'h5, 1'b0, 4'h0, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // preload the carry flag via an add: 15+1 carries, 0+1 does not
  task automatic set_cf(input logic v);
    @(negedge clk);
    src_a_sel = 2'd1; src_b_sel = 2'd2; op = 4'd0;
    b_in = v ? 4'hF : 4'h0; flag_we = 1'b1;
    @(negedge clk);
    flag_we = 1'b0;
  endtask

  function automatic int model(input int opc, input int a, input int bo,
                               input int cf, input int nc_sel);
    int s, cn, r;
    cn = cf; r = 0;
    case (opc)
      0: begin s = a + bo;          r = s & 15; cn = s >> 4; end
      1: begin s = a + bo + 1;      r = s & 15; cn = 1 - (s >> 4); end
      2: begin s = a + bo + cf;     r = s & 15; cn = s >> 4; end
      3: begin s = a + bo + 1 - cf; r = s & 15; cn = 1 - (s >> 4); end
      4: begin r = (cf << 3) | (a >> 1); cn = a & 1; end
      5: r = a & bo;
      6: r = a | bo;
      7: r = nc_sel ? bo : (a ^ bo);
      8: r = (~a) & 15;
      default: r = 0;
    endcase
    return (cn << 4) | r;
  endfunction

  function automatic string tag_of(input int opc);
    case (opc)
      0: return "R4";
      1: return "R5";
      2, 3: return "R6";
      4: return "R7";
      5, 6, 7, 8: return "R8";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", carry_q, 0);
    rst = 1'b0;
    set_cf(1'b1);
    check("R12 load one", carry_q, 1);
    // R1: reset wins over a write strobe that would set the flag
    src_a_sel = 2'd1; src_b_sel = 2'd2; op = 4'd0; b_in = 4'hF;
    flag_we = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R1 reset over write", carry_q, 0);
    rst = 1'b0; flag_we = 1'b0;
    // R12: no strobe, flag holds despite carry_next=1
    @(negedge clk);
    check("R12 hold", carry_q, 0);

    // table of directed vectors
    for (int i = 0; i < NV; i++) begin
      set_cf(VECS[i].cf);
      src_a_sel = VECS[i].asel; src_b_sel = VECS[i].bsel; op = VECS[i].opc;
      b_in = VECS[i].bv; c_in = VECS[i].cv; pc_in = 4'h3; y_in = 4'h6; imm_in = 4'hE;
      #1;
      check($sformatf("R%0d vec%0d result", VECS[i].tag, i), result, VECS[i].res);
      check($sformatf("R%0d vec%0d carry", VECS[i].tag, i), carry_next, VECS[i].cn);
      check($sformatf("R11 vec%0d zero", i), zero, (VECS[i].res == 4'h0) ? 1 : 0);
      @(negedge clk);
      flag_we = 1'b1;
      @(negedge clk);
      flag_we = 1'b0;
      check($sformatf("R12 vec%0d commit", i), carry_q, VECS[i].cn);
    end

    // R9: XOR with complemented C ignores the left operand
    set_cf(1'b0);
    src_a_sel = 2'd1; src_b_sel = 2'd1; op = 4'd7; c_in = 4'h3;
    for (int a = 0; a < 16; a++) begin
      b_in = 4'(a); #1;
      check("R9 xor nc", result, 4'hC);
    end

    // R2: all four left selects with distinct sources, NOT exposes left
    pc_in = 4'h1; b_in = 4'h2; y_in = 4'h4; op = 4'd8;
    for (int s = 0; s < 4; s++) begin
      src_a_sel = 2'(s); #1;
      check("R2 left select", result, (s == 0) ? 4'hE : (s == 1) ? 4'hD : 4'hB);
    end

    // exhaustive sweep against the model, left via B
    src_a_sel = 2'd1;
    for (int cf = 0; cf < 2; cf++) begin
      set_cf(cf[0]);
      for (int o = 0; o < 16; o++)
        for (int a = 0; a < 16; a++)
          for (int c = 0; c < 16; c++)
            for (int bs = 0; bs < 4; bs++) begin
              int bo, exp;
              op = 4'(o); b_in = 4'(a); c_in = 4'(c); imm_in = 4'(c ^ 5);
              src_b_sel = 2'(bs);
              bo = (bs == 0) ? c : (bs == 1) ? (15 - c) : (bs == 2) ? 1 : (c ^ 5);
              exp = model(o, a, bo, cf, (bs == 1) ? 1 : 0);
              #1;
              checks++;
              if ({carry_next, result} !== 5'(exp) || zero !== ((exp & 15) == 0)) begin
                errors++;
                $display("FAIL %s/R3/R11 op=%0d a=%0h c=%0h bsel=%0d cf=%0d actual=%0h expected=%0h",
                         tag_of(o), o, a, c, bs, cf, {zero, carry_next, result},
                         {((exp & 15) == 0), 5'(exp)});
              end
            end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule